// File: doc/BRIEF.md
# Landing-Pad Expectation Save/Restore Unit

This unit keeps the single "landing pad expected" bit of a hart and the saved copies of it that live in the machine status, the two supervisor status views (non-virtual and virtual) and the debug control register. When a trap or a debug halt is taken, the live bit is stashed in the copy that belongs to the destination and then cleared. On the matching return, the live bit is reloaded only if landing pads are enabled for the privilege and virtualization being resumed.

Event pulses come from the pipeline's trap and return logic. Per-mode enables come from the configuration registers. The saved copies appear on output ports so that CSR read logic can merge them into the status views. A separate update port lets the control-flow logic load the live bit when no trap or return is in progress. All state changes on the rising clock edge. At most one event is applied per cycle, chosen by a fixed priority.

Top module: `lpad_state_keeper`

## Requirements
- R1: After reset, the live bit, every saved copy, the saved debug privilege and the saved debug virtualization bit are all 0. A value of 1 means a landing pad is expected.
- R2: A machine trap copies the live bit into the machine saved copy and clears the live bit on the same edge.
- R3: A trap into HS copies the live bit into the non-virtual supervisor copy. A trap into VS copies it into the virtual supervisor copy. Each leaves the other supervisor copy unchanged and clears the live bit.
- R4: Debug entry copies the live bit, the current privilege and the current virtualization bit into the debug saved fields, and clears the live bit.
- R5: If the enable for the MRET target (privilege from mpp_i, virtualization from mpv_i, virtualization ignored when the target is M) is 1, MRET loads the live bit from the machine copy and clears that copy. If the enable is 0, neither changes.
- R6: SRET uses the virtual supervisor copy when cur_virt_i is 1 and the non-virtual copy otherwise. If the enable for the target (sret_priv_i, sret_virt_i) is 1, the live bit is loaded from that copy and the copy is cleared. If the enable is 0, neither changes.
- R7: DRET reloads the live bit from the debug copy when the enable for the saved debug privilege and virtualization is 1. It never clears the debug copy.
- R8: The enable is selected from lpe_en_i as follows: bit 0 for M, bit 1 for non-virtual S, bit 2 for non-virtual U, bit 3 for VS and bit 4 for VU. Privilege encoding is U=0, S=1, M=3. The value 2 always selects disabled.
- R9: When several events are asserted in one cycle, only the highest applies. The order from highest to lowest is debug entry, M trap, HS trap, VS trap, DRET, MRET, SRET, update.
- R10: An update pulse with no other event loads upd_val_i into the live bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_i | input | 1 | Debug entry pulse |
| trap_m_i | input | 1 | Trap into M pulse |
| trap_hs_i | input | 1 | Trap into HS pulse |
| trap_vs_i | input | 1 | Trap into VS pulse |
| dret_i | input | 1 | Debug return pulse |
| mret_i | input | 1 | Machine return pulse |
| sret_i | input | 1 | Supervisor return pulse |
| upd_i | input | 1 | Live-bit update pulse |
| upd_val_i | input | 1 | Value for the update |
| cur_priv_i | input | 2 | Current privilege |
| cur_virt_i | input | 1 | Current virtualization bit |
| mpp_i | input | 2 | MRET target privilege |
| mpv_i | input | 1 | MRET target virtualization |
| sret_priv_i | input | 2 | SRET target privilege |
| sret_virt_i | input | 1 | SRET target virtualization |
| lpe_en_i | input | 5 | Per-mode landing-pad enables |
| elp_o | output | 1 | Live expectation bit |
| mpelp_o | output | 1 | Machine saved copy |
| spelp_ns_o | output | 1 | Non-virtual supervisor saved copy |
| spelp_v_o | output | 1 | Virtual supervisor saved copy |
| dpelp_o | output | 1 | Debug saved copy |
| dprv_o | output | 2 | Saved debug privilege |
| dv_o | output | 1 | Saved debug virtualization bit |

## Verification
Every result is registered exactly once, so each output reflects an event one rising edge after the event is sampled. The bench drives each event on a falling edge and removes it on the next falling edge. It compares all seven outputs against its model at that second falling edge, which falls half a period after the edge that applied the event. Because each event is a single-cycle pulse, any effect that lingered or arrived a cycle late would show up as a mismatch at the following comparison.

// File: rtl/lpad_pkg.sv
package lpad_pkg;
  localparam int PRV_W  = 2;
  localparam int NUM_EN = 5;
  localparam int NUM_EV = 8;

  localparam logic [PRV_W-1:0] PRV_U = 2'd0;
  localparam logic [PRV_W-1:0] PRV_S = 2'd1;
  localparam logic [PRV_W-1:0] PRV_M = 2'd3;

  // enable bit positions
  localparam int EN_M  = 0;
  localparam int EN_S  = 1;
  localparam int EN_U  = 2;
  localparam int EN_VS = 3;
  localparam int EN_VU = 4;

  // request positions, highest priority first
  localparam int RQ_DBG  = 0;
  localparam int RQ_TM   = 1;
  localparam int RQ_THS  = 2;
  localparam int RQ_TVS  = 3;
  localparam int RQ_DRET = 4;
  localparam int RQ_MRET = 5;
  localparam int RQ_SRET = 6;
  localparam int RQ_UPD  = 7;

  function automatic logic lpe_for(input logic [PRV_W-1:0] prv, input logic virt,
                                   input logic [NUM_EN-1:0] en);
    logic r;
    r = 1'b0;
    if (prv == PRV_M)      r = en[EN_M];
    else if (prv == PRV_S) r = virt ? en[EN_VS] : en[EN_S];
    else if (prv == PRV_U) r = virt ? en[EN_VU] : en[EN_U];
    return r;
  endfunction
endpackage

// File: rtl/lpad_prio_arb.sv
module lpad_prio_arb #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [N-1:0] seen;
  always_comb begin
    seen[0] = 1'b0;
    for (int i = 1; i < N; i++) seen[i] = seen[i-1] | req[i-1];
  end
  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gnt[g] = req[g] & ~seen[g];
  end
endmodule

// File: rtl/lpad_en_sel.sv
module lpad_en_sel
  import lpad_pkg::*;
(
  input  logic [PRV_W-1:0]  prv,
  input  logic              virt,
  input  logic [NUM_EN-1:0] en,
  output logic              on
);
  assign on = lpe_for(prv, virt, en);
endmodule

// File: rtl/lpad_state_keeper.sv
module lpad_state_keeper
  import lpad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_i,
  input  logic              trap_m_i,
  input  logic              trap_hs_i,
  input  logic              trap_vs_i,
  input  logic              dret_i,
  input  logic              mret_i,
  input  logic              sret_i,
  input  logic              upd_i,
  input  logic              upd_val_i,
  input  logic [1:0]        cur_priv_i,
  input  logic              cur_virt_i,
  input  logic [1:0]        mpp_i,
  input  logic              mpv_i,
  input  logic [1:0]        sret_priv_i,
  input  logic              sret_virt_i,
  input  logic [4:0]        lpe_en_i,
  output logic              elp_o,
  output logic              mpelp_o,
  output logic              spelp_ns_o,
  output logic              spelp_v_o,
  output logic              dpelp_o,
  output logic [1:0]        dprv_o,
  output logic              dv_o
);
  logic [NUM_EV-1:0] req, gnt;
  logic win_dbg, win_trap_m, win_trap_hs, win_trap_vs;
  logic win_dret, win_mret, win_sret, win_upd;
  logic en_mret, en_sret, en_dret;
  logic sret_src;

  logic             elp_q, mpelp_q, spelp_ns_q, spelp_v_q, dpelp_q, dv_q;
  logic [PRV_W-1:0] dprv_q;
  logic             elp_d, mpelp_d, spelp_ns_d, spelp_v_d, dpelp_d, dv_d;
  logic [PRV_W-1:0] dprv_d;

  always_comb begin
    req          = '0;
    req[RQ_DBG]  = dbg_i;
    req[RQ_TM]   = trap_m_i;
    req[RQ_THS]  = trap_hs_i;
    req[RQ_TVS]  = trap_vs_i;
    req[RQ_DRET] = dret_i;
    req[RQ_MRET] = mret_i;
    req[RQ_SRET] = sret_i;
    req[RQ_UPD]  = upd_i;
  end

  lpad_prio_arb #(.N(NUM_EV)) u_arb (.req(req), .gnt(gnt));

  assign win_dbg     = gnt[RQ_DBG];
  assign win_trap_m  = gnt[RQ_TM];
  assign win_trap_hs = gnt[RQ_THS];
  assign win_trap_vs = gnt[RQ_TVS];
  assign win_dret    = gnt[RQ_DRET];
  assign win_mret    = gnt[RQ_MRET];
  assign win_sret    = gnt[RQ_SRET];
  assign win_upd     = gnt[RQ_UPD];

  lpad_en_sel u_en_m (.prv(mpp_i),       .virt(mpv_i),       .en(lpe_en_i), .on(en_mret));
  lpad_en_sel u_en_s (.prv(sret_priv_i), .virt(sret_virt_i), .en(lpe_en_i), .on(en_sret));
  lpad_en_sel u_en_d (.prv(dprv_q),      .virt(dv_q),        .en(lpe_en_i), .on(en_dret));

  assign sret_src = cur_virt_i ? spelp_v_q : spelp_ns_q;

  always_comb begin
    elp_d      = elp_q;
    mpelp_d    = mpelp_q;
    spelp_ns_d = spelp_ns_q;
    spelp_v_d  = spelp_v_q;
    dpelp_d    = dpelp_q;
    dprv_d     = dprv_q;
    dv_d       = dv_q;
    if (win_dbg) begin
      dpelp_d = elp_q;
      dprv_d  = cur_priv_i;
      dv_d    = cur_virt_i;
      elp_d   = 1'b0;
    end else if (win_trap_m) begin
      mpelp_d = elp_q;
      elp_d   = 1'b0;
    end else if (win_trap_hs) begin
      spelp_ns_d = elp_q;
      elp_d      = 1'b0;
    end else if (win_trap_vs) begin
      spelp_v_d = elp_q;
      elp_d     = 1'b0;
    end else if (win_dret) begin
      if (en_dret) elp_d = dpelp_q;
    end else if (win_mret) begin
      if (en_mret) begin
        elp_d   = mpelp_q;
        mpelp_d = 1'b0;
      end
    end else if (win_sret) begin
      if (en_sret) begin
        elp_d = sret_src;
        if (cur_virt_i) spelp_v_d  = 1'b0;
        else            spelp_ns_d = 1'b0;
      end
    end else if (win_upd) begin
      elp_d = upd_val_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elp_q      <= 1'b0;
      mpelp_q    <= 1'b0;
      spelp_ns_q <= 1'b0;
      spelp_v_q  <= 1'b0;
      dpelp_q    <= 1'b0;
      dprv_q     <= '0;
      dv_q       <= 1'b0;
    end else begin
      elp_q      <= elp_d;
      mpelp_q    <= mpelp_d;
      spelp_ns_q <= spelp_ns_d;
      spelp_v_q  <= spelp_v_d;
      dpelp_q    <= dpelp_d;
      dprv_q     <= dprv_d;
      dv_q       <= dv_d;
    end
  end

  assign elp_o      = elp_q;
  assign mpelp_o    = mpelp_q;
  assign spelp_ns_o = spelp_ns_q;
  assign spelp_v_o  = spelp_v_q;
  assign dpelp_o    = dpelp_q;
  assign dprv_o     = dprv_q;
  assign dv_o       = dv_q;
endmodule

// File: rtl/lpad_state_keeper_chk.sv
module lpad_state_keeper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dbg_i, trap_m_i, trap_hs_i, trap_vs_i,
  input logic       dret_i, mret_i, sret_i,
  input logic       win_dbg, win_trap_m, win_trap_hs, win_trap_vs,
  input logic       win_dret, win_mret, win_sret, win_upd,
  input logic       en_mret, en_sret, en_dret,
  input logic [1:0] cur_priv_i,
  input logic       cur_virt_i,
  input logic       elp_o, mpelp_o, spelp_ns_o, spelp_v_o, dpelp_o,
  input logic [1:0] dprv_o,
  input logic       dv_o
);
  AST_TRAP_CLEARS_ELP: assert property (@(posedge clk) disable iff (!rst_n)
    (win_dbg | win_trap_m | win_trap_hs | win_trap_vs) |=> !elp_o); // R2
  AST_MTRAP_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    win_trap_m |=> mpelp_o == $past(elp_o)); // R2
  AST_HSTRAP_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    win_trap_hs |=> spelp_ns_o == $past(elp_o) && $stable(spelp_v_o)); // R3
  AST_VSTRAP_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    win_trap_vs |=> spelp_v_o == $past(elp_o) && $stable(spelp_ns_o)); // R3
  AST_DBG_SAVES: assert property (@(posedge clk) disable iff (!rst_n)
    win_dbg |=> dpelp_o == $past(elp_o) && dprv_o == $past(cur_priv_i)
               && dv_o == $past(cur_virt_i)); // R4
  AST_MRET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mret && en_mret) |=> elp_o == $past(mpelp_o) && !mpelp_o); // R5
  AST_MRET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (win_mret && !en_mret) |=> $stable(elp_o) && $stable(mpelp_o)); // R5
  AST_SRET_NS_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sret && en_sret && !cur_virt_i) |=> elp_o == $past(spelp_ns_o) && !spelp_ns_o); // R6
  AST_SRET_V_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_sret && en_sret && cur_virt_i) |=> elp_o == $past(spelp_v_o) && !spelp_v_o); // R6
  AST_DRET_KEEPS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    win_dret |=> $stable(dpelp_o)); // R7
  AST_DRET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
    (win_dret && en_dret) |=> elp_o == $past(dpelp_o)); // R7
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({win_dbg, win_trap_m, win_trap_hs, win_trap_vs,
              win_dret, win_mret, win_sret, win_upd})); // R9
  AST_TRAP_BEATS_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    ((dbg_i | trap_m_i | trap_hs_i | trap_vs_i) && (dret_i | mret_i | sret_i))
      |-> !(win_dret | win_mret | win_sret)); // R9
endmodule

bind lpad_state_keeper lpad_state_keeper_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .dbg_i(dbg_i), .trap_m_i(trap_m_i), .trap_hs_i(trap_hs_i), .trap_vs_i(trap_vs_i),
  .dret_i(dret_i), .mret_i(mret_i), .sret_i(sret_i),
  .win_dbg(win_dbg), .win_trap_m(win_trap_m), .win_trap_hs(win_trap_hs),
  .win_trap_vs(win_trap_vs), .win_dret(win_dret), .win_mret(win_mret),
  .win_sret(win_sret), .win_upd(win_upd),
  .en_mret(en_mret), .en_sret(en_sret), .en_dret(en_dret),
  .cur_priv_i(cur_priv_i), .cur_virt_i(cur_virt_i),
  .elp_o(elp_o), .mpelp_o(mpelp_o), .spelp_ns_o(spelp_ns_o), .spelp_v_o(spelp_v_o),
  .dpelp_o(dpelp_o), .dprv_o(dprv_o), .dv_o(dv_o)
);

// File: tb/tb_lpad_state_keeper.sv
`timescale 1ns/1ps
module tb_lpad_state_keeper;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_i = 0, trap_m_i = 0, trap_hs_i = 0, trap_vs_i = 0;
  logic dret_i = 0, mret_i = 0, sret_i = 0, upd_i = 0, upd_val_i = 0;
  logic [1:0] cur_priv_i = 2'd3, mpp_i = 2'd0, sret_priv_i = 2'd0;
  logic cur_virt_i = 0, mpv_i = 0, sret_virt_i = 0;
  logic [4:0] lpe_en_i = 5'b0;
  logic elp_o, mpelp_o, spelp_ns_o, spelp_v_o, dpelp_o, dv_o;
  logic [1:0] dprv_o;

  int nvec = 0;
  int nfail = 0;

  // reference state
  logic m_elp = 0, m_mp = 0, m_sns = 0, m_sv = 0, m_dp = 0, m_dv = 0;
  logic [1:0] m_dprv = 0;

  always #4 clk = ~clk;

  lpad_state_keeper dut (.*);

  // enable lookup restated from R8 as a table index
  function automatic logic ref_en(input logic [1:0] p, input logic v, input logic [4:0] e);
    case ({v, p})
      3'b011, 3'b111: return e[0];
      3'b001: return e[1];
      3'b000: return e[2];
      3'b101: return e[3];
      3'b100: return e[4];
      default: return 1'b0;
    endcase
  endfunction

  task automatic compare(input string tag);
    logic [7:0] got, exp;
    got = {elp_o, mpelp_o, spelp_ns_o, spelp_v_o, dpelp_o, dprv_o, dv_o};
    exp = {m_elp, m_mp, m_sns, m_sv, m_dp, m_dprv, m_dv};
    nvec++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got elp/mp/sns/sv/dp/dprv/dv=%b expected %b", tag, got, exp);
    end
  endtask

  // ev bits: 0 dbg,1 trapM,2 trapHS,3 trapVS,4 dret,5 mret,6 sret,7 upd
  task automatic step(input logic [7:0] ev, input logic uval, input string tag);
    if (ev[0]) begin
      m_dp = m_elp; m_dprv = cur_priv_i; m_dv = cur_virt_i; m_elp = 0;
    end else if (ev[1]) begin
      m_mp = m_elp; m_elp = 0;
    end else if (ev[2]) begin
      m_sns = m_elp; m_elp = 0;
    end else if (ev[3]) begin
      m_sv = m_elp; m_elp = 0;
    end else if (ev[4]) begin
      if (ref_en(m_dprv, m_dv, lpe_en_i)) m_elp = m_dp;
    end else if (ev[5]) begin
      if (ref_en(mpp_i, mpv_i, lpe_en_i)) begin m_elp = m_mp; m_mp = 0; end
    end else if (ev[6]) begin
      if (ref_en(sret_priv_i, sret_virt_i, lpe_en_i)) begin
        if (cur_virt_i) begin m_elp = m_sv;  m_sv = 0;  end
        else            begin m_elp = m_sns; m_sns = 0; end
      end
    end else if (ev[7]) begin
      m_elp = uval;
    end
    {upd_i, sret_i, mret_i, dret_i, trap_vs_i, trap_hs_i, trap_m_i, dbg_i} = ev;
    upd_val_i = uval;
    @(negedge clk);
    {upd_i, sret_i, mret_i, dret_i, trap_vs_i, trap_hs_i, trap_m_i, dbg_i} = 8'h00;
    upd_val_i = 0;
    compare(tag);
  endtask

  task automatic t_reset;
    compare("R1 reset values");
  endtask

  task automatic t_update;
    step(8'h80, 1'b1, "R10 update to 1");
    step(8'h80, 1'b0, "R10 update to 0");
    step(8'h80, 1'b1, "R10 update to 1 again");
  endtask

  task automatic t_mtrap_mret;
    for (int v = 0; v < 2; v++)
      for (int on = 0; on < 2; on++) begin
        step(8'h80, v[0], "R10 preset");
        step(8'h02, 1'b0, "R2 M trap save/clear");
        mpp_i = 2'd0; mpv_i = 0;
        lpe_en_i = on[0] ? 5'b00100 : 5'b11011;
        step(8'h20, 1'b0, "R5 MRET to U");
        mpp_i = 2'd3; mpv_i = 1; lpe_en_i = 5'b00001;
        step(8'h20, 1'b0, "R5 MRET to M, virt ignored");
      end
  endtask

  task automatic t_strap_sret;
    for (int v = 0; v < 2; v++)
      for (int on = 0; on < 2; on++) begin
        step(8'h80, v[0], "R10 preset");
        step(8'h04, 1'b0, "R3 HS trap");
        step(8'h80, ~v[0], "R10 preset other");
        step(8'h08, 1'b0, "R3 VS trap");
        cur_virt_i = 0; sret_priv_i = 2'd1; sret_virt_i = 0;
        lpe_en_i = on[0] ? 5'b00010 : 5'b11101;
        step(8'h40, 1'b0, "R6 SRET non-virtual to S");
        cur_virt_i = 1; sret_priv_i = 2'd0; sret_virt_i = 1;
        lpe_en_i = on[0] ? 5'b10000 : 5'b01111;
        step(8'h40, 1'b0, "R6 SRET virtual to VU");
        cur_virt_i = 0;
      end
  endtask

  task automatic t_debug;
    for (int v = 0; v < 2; v++)
      for (int on = 0; on < 2; on++) begin
        step(8'h80, v[0], "R10 preset");
        cur_priv_i = 2'd1; cur_virt_i = 1;
        step(8'h01, 1'b0, "R4 debug entry");
        cur_priv_i = 2'd3; cur_virt_i = 0;
        lpe_en_i = on[0] ? 5'b01000 : 5'b10111;
        step(8'h10, 1'b0, "R7 DRET to VS");
        step(8'h80, 1'b0, "R10 clear");
        step(8'h10, 1'b0, "R7 second DRET keeps copy");
      end
  endtask

  task automatic t_enable_map;
    logic [1:0] tp [5] = '{2'd3, 2'd1, 2'd0, 2'd1, 2'd0};
    logic       tv [5] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1};
    for (int k = 0; k < 5; k++)
      for (int on = 0; on < 2; on++) begin
        step(8'h80, 1'b1, "R10 preset");
        step(8'h02, 1'b0, "R2 M trap");
        mpp_i = tp[k]; mpv_i = tv[k];
        lpe_en_i = on[0] ? (5'b1 << k) : ~(5'b1 << k);
        step(8'h20, 1'b0, "R8 enable bit select");
      end
    mpp_i = 2'd2; mpv_i = 0; lpe_en_i = 5'b11111;
    step(8'h80, 1'b1, "R10 preset");
    step(8'h02, 1'b0, "R2 M trap");
    step(8'h20, 1'b0, "R8 reserved privilege disabled");
  endtask

  task automatic t_priority;
    lpe_en_i = 5'b11111; mpp_i = 2'd3; mpv_i = 0;
    step(8'h80, 1'b1, "R10 preset");
    step(8'h22, 1'b0, "R9 M trap beats MRET");
    step(8'h80, 1'b1, "R10 preset");
    cur_priv_i = 2'd0; cur_virt_i = 0;
    step(8'h03, 1'b0, "R9 debug beats M trap");
    step(8'h80, 1'b1, "R10 preset");
    step(8'h0C, 1'b0, "R9 HS trap beats VS trap");
    sret_priv_i = 2'd1; sret_virt_i = 0;
    step(8'h50, 1'b0, "R9 DRET beats SRET");
    step(8'hC0, 1'b1, "R9 SRET beats update");
    step(8'h60, 1'b0, "R9 MRET beats SRET");
  endtask

  initial begin
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_update();
    t_mtrap_mret();
    t_strap_sret();
    t_debug();
    t_enable_map();
    t_priority();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule